// File: doc/BRIEF.md
# Time-Slot Crossbar Schedule Controller

This block sets the configuration of a small input-queued crossbar from a precomputed periodic schedule. Nothing is arbitrated from requests. A table holds one connection entry per time-slot, and each entry is a conflict-free matching of input ports to output ports. A slot counter walks through the table once per scheduling frame. It holds each slot for a fixed number of clock cycles and then wraps back to slot zero. For the slot in progress, the block drives the entry as a crossbar connection map and decodes it into a grant vector with one bit per virtual output queue.

The schedule is loaded through a simple write port while the controller is halted. Every entry is checked on its way in, and an entry that connects one input to two outputs is refused and flagged. When the controller is started, it begins at a programmable slot offset. This lets the same schedule run rotated, so neighbouring switches need no common frame phase. A one-cycle pulse marks the first cycle of slot zero in every frame.

Top module: `xs_slot_ctrl`

## Requirements
- R1: While rst_ni is low, xbar_map_o, grant_o, frame_start_o, ld_ack_o and ld_err_o are all zero.
- R2: In the cycle after any clock edge at which run_i is low, xbar_map_o and grant_o are zero.
- R3: For output port k, the field of xbar_map_o at bits [3k+2:3k] is a valid bit (bit 3k+2) and a 2-bit source input index (bits 3k+1:3k). Bit j*4+k of grant_o is 1 exactly when output k is valid with source j.
- R4: While running, every slot is shown for SLOT_CYCLES consecutive clock cycles (13 by default). After that, slot_o advances by one.
- R5: After slot FRAME_LEN-1 (1023 by default), the next slot is 0.
- R6: In the first cycle after the edge at which run_i is first seen high, slot_o equals offset_i and xbar_map_o holds the table entry stored at that address.
- R7: frame_start_o is high for exactly the first cycle of slot 0, and low in every other cycle.
- R8: A write request (ld_we_i) is stored only when run_i is low. An accepted write gives a one-cycle ld_ack_o pulse in the next cycle. A write made while running changes nothing and raises neither ld_ack_o nor ld_err_o.
- R9: A write whose entry has two valid outputs with the same source index is refused. It gives a one-cycle ld_err_o pulse in the next cycle and leaves the stored entry as it was. Outputs that share a source index are not a conflict if their valid bits are clear.
- R10: At any time, each input port is granted towards at most one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to run the schedule, low to halt it and allow loading |
| offset_i | input | 10 | Slot index at which a run starts |
| ld_we_i | input | 1 | Table write request |
| ld_addr_i | input | 10 | Table write address (slot index) |
| ld_data_i | input | 12 | Table write entry, same encoding as xbar_map_o |
| ld_ack_o | output | 1 | Pulse: previous write stored |
| ld_err_o | output | 1 | Pulse: previous write refused because of a conflict |
| slot_o | output | 10 | Current slot index |
| frame_start_o | output | 1 | Pulse in the first cycle of slot 0 |
| xbar_map_o | output | 12 | Per-output valid bit and source index for the current slot |
| grant_o | output | 16 | Per-VOQ service grant, bit j*4+k for input j to output k |

## Verification
The hardest case to reach from the ports is the frame wrap seen together with a refused entry. Only the outputs of a running controller show the table contents, and reaching slot zero from reset normally takes a whole frame of 13,312 cycles. The stimulus fills the table with a computed pattern and then tries a conflicting write to the last address. It starts the run at offset 1022, so the refused entry and the wrap both appear within a few dozen cycles. A write made during the run is then followed to the slot it targeted, to show that the write was ignored.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int unsigned DEF_PORTS = 4;
  localparam int unsigned DEF_FRAME = 1024;
  localparam int unsigned DEF_DWELL = 13;

  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xs_slot_timer.sv
module xs_slot_timer #(
  parameter int unsigned FRAME_LEN   = xs_pkg::DEF_FRAME,
  parameter int unsigned SLOT_CYCLES = xs_pkg::DEF_DWELL,
  parameter int unsigned SLOT_W      = xs_pkg::idx_w(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] offset_i,
  output logic              active_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o
);
  localparam int unsigned PH_W = xs_pkg::idx_w(SLOT_CYCLES);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

  logic              active_q;
  logic [PH_W-1:0]   phase_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      slot_q   <= '0;
    end else if (!run_i || !active_q) begin
      // halted, or first cycle of a run: park on the start offset
      active_q <= run_i;
      phase_q  <= '0;
      slot_q   <= offset_i;
    end else if (phase_q == LAST_PH) begin
      phase_q <= '0;
      slot_q  <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign active_o      = active_q;
  assign slot_o        = slot_q;
  assign frame_start_o = active_q && (slot_q == '0) && (phase_q == '0);
endmodule

// File: rtl/xs_sched_table.sv
module xs_sched_table #(
  parameter int unsigned DEPTH   = xs_pkg::DEF_FRAME,
  parameter int unsigned ENTRY_W = 12,
  parameter int unsigned AW      = xs_pkg::idx_w(DEPTH)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xs_grant_decode.sv
module xs_grant_decode #(
  parameter int unsigned NUM_PORTS = xs_pkg::DEF_PORTS,
  parameter int unsigned SRC_W     = xs_pkg::idx_w(NUM_PORTS),
  parameter int unsigned FLD_W     = SRC_W + 1,
  parameter int unsigned ENTRY_W   = NUM_PORTS * FLD_W
) (
  input  logic [ENTRY_W-1:0]             entry_i,
  output logic [NUM_PORTS*NUM_PORTS-1:0] grant_o
);
  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_in
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_out
      assign grant_o[j*NUM_PORTS+k] = entry_i[k*FLD_W+SRC_W] &&
                                      (entry_i[k*FLD_W +: SRC_W] == SRC_W'(j));
    end
  end
endmodule

// File: rtl/xs_load_check.sv
module xs_load_check #(
  parameter int unsigned NUM_PORTS = xs_pkg::DEF_PORTS,
  parameter int unsigned SRC_W     = xs_pkg::idx_w(NUM_PORTS),
  parameter int unsigned ENTRY_W   = NUM_PORTS * (SRC_W + 1)
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               conflict_o
);
  logic [NUM_PORTS*NUM_PORTS-1:0] req;
  logic [NUM_PORTS-1:0]           row_multi;

  xs_grant_decode #(.NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)) u_dec (
    .entry_i (entry_i),
    .grant_o (req)
  );

  // an input claimed by more than one output breaks the matching
  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_row
    always_comb begin
      logic seen;
      seen         = 1'b0;
      row_multi[j] = 1'b0;
      for (int k = 0; k < NUM_PORTS; k++) begin
        if (req[j*NUM_PORTS+k]) begin
          if (seen) row_multi[j] = 1'b1;
          seen = 1'b1;
        end
      end
    end
  end

  assign conflict_o = |row_multi;
endmodule

// File: rtl/xs_slot_ctrl.sv
module xs_slot_ctrl #(
  parameter int unsigned NUM_PORTS   = xs_pkg::DEF_PORTS,
  parameter int unsigned FRAME_LEN   = xs_pkg::DEF_FRAME,
  parameter int unsigned SLOT_CYCLES = xs_pkg::DEF_DWELL,
  parameter int unsigned SLOT_W      = xs_pkg::idx_w(FRAME_LEN),
  parameter int unsigned SRC_W       = xs_pkg::idx_w(NUM_PORTS),
  parameter int unsigned ENTRY_W     = NUM_PORTS * (SRC_W + 1),
  parameter int unsigned GRANT_W     = NUM_PORTS * NUM_PORTS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SLOT_W-1:0]  offset_i,
  input  logic               ld_we_i,
  input  logic [SLOT_W-1:0]  ld_addr_i,
  input  logic [ENTRY_W-1:0] ld_data_i,
  output logic               ld_ack_o,
  output logic               ld_err_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               frame_start_o,
  output logic [ENTRY_W-1:0] xbar_map_o,
  output logic [GRANT_W-1:0] grant_o
);
  logic               active;
  logic [SLOT_W-1:0]  slot;
  logic [ENTRY_W-1:0] rd_entry;
  logic               conflict;
  logic               wr_req;
  logic               wr_en;
  logic               ack_q, err_q;

  xs_slot_timer #(
    .FRAME_LEN(FRAME_LEN), .SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(SLOT_W)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run_i),
    .offset_i      (offset_i),
    .active_o      (active),
    .slot_o        (slot),
    .frame_start_o (frame_start_o)
  );

  xs_load_check #(.NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)) u_check (
    .entry_i    (ld_data_i),
    .conflict_o (conflict)
  );

  assign wr_req = ld_we_i && !run_i;
  assign wr_en  = wr_req && !conflict;

  xs_sched_table #(.DEPTH(FRAME_LEN), .ENTRY_W(ENTRY_W), .AW(SLOT_W)) u_table (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (slot),
    .rdata_o (rd_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= wr_en;
      err_q <= wr_req && conflict;
    end
  end

  assign xbar_map_o = active ? rd_entry : '0;

  xs_grant_decode #(.NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)) u_grant (
    .entry_i (xbar_map_o),
    .grant_o (grant_o)
  );

  assign ld_ack_o = ack_q;
  assign ld_err_o = err_q;
  assign slot_o   = slot;
endmodule

// File: rtl/xs_slot_ctrl_chk.sv
module xs_slot_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned FRAME_LEN = 1024,
  parameter int unsigned SLOT_W    = 10,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned ENTRY_W   = 12,
  parameter int unsigned GRANT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_i,
  input logic               ld_we_i,
  input logic               ld_ack_o,
  input logic               ld_err_o,
  input logic [SLOT_W-1:0]  slot_o,
  input logic               frame_start_o,
  input logic [ENTRY_W-1:0] xbar_map_o,
  input logic [GRANT_W-1:0] grant_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

  function automatic int unsigned valid_cnt(input logic [ENTRY_W-1:0] e);
    int unsigned n;
    n = 0;
    for (int k = 0; k < NUM_PORTS; k++) n += int'(e[k*(SRC_W+1)+SRC_W]);
    return n;
  endfunction

  // R2
  a_r2_halt_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (xbar_map_o == '0 && grant_o == '0));

  // R3
  a_r3_grant_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == valid_cnt(xbar_map_o));

  // R4
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $past(run_i, 2) && $past(slot_o) != LAST_SLOT &&
     !$stable(slot_o)) |-> slot_o == $past(slot_o) + 1'b1);

  // R5
  a_r5_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $past(run_i, 2) && $past(slot_o) == LAST_SLOT &&
     !$stable(slot_o)) |-> slot_o == '0);

  // R7
  a_r7_frame_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (slot_o == '0 && run_i));

  a_r7_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  // R8
  a_r8_locked_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ld_we_i) |=> (!ld_ack_o && !ld_err_o));

  // R9
  a_r9_ack_xor_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_err_o |-> !ld_ack_o);

  // R10
  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_in
    a_r10_one_out_per_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(grant_o[j*NUM_PORTS +: NUM_PORTS]) <= 1);
  end
endmodule

bind xs_slot_ctrl xs_slot_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .FRAME_LEN(FRAME_LEN), .SLOT_W(SLOT_W),
  .SRC_W(SRC_W), .ENTRY_W(ENTRY_W), .GRANT_W(GRANT_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .run_i         (run_i),
  .ld_we_i       (ld_we_i),
  .ld_ack_o      (ld_ack_o),
  .ld_err_o      (ld_err_o),
  .slot_o        (slot_o),
  .frame_start_o (frame_start_o),
  .xbar_map_o    (xbar_map_o),
  .grant_o       (grant_o)
);

// File: tb/xs_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module xs_slot_ctrl_tb_top;
  localparam int FRAME = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [9:0]  offset = '0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [11:0] data = '0;
  logic        ack, err, fstart;
  logic [9:0]  slot;
  logic [11:0] map;
  logic [15:0] grant;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xs_slot_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .offset_i(offset),
    .ld_we_i(we), .ld_addr_i(addr), .ld_data_i(data),
    .ld_ack_o(ack), .ld_err_o(err), .slot_o(slot),
    .frame_start_o(fstart), .xbar_map_o(map), .grant_o(grant)
  );

  // entry for slot i: output k takes input (k+i)%4, output i%5 left idle
  function automatic logic [11:0] pat(input int i);
    logic [11:0] e;
    e = '0;
    for (int k = 0; k < 4; k++) begin
      e[3*k +: 2] = 2'((k + i) % 4);
      e[3*k + 2]  = (k != (i % 5));
    end
    return e;
  endfunction

  function automatic logic [15:0] exp_grant(input logic [11:0] e);
    logic [15:0] g;
    g = '0;
    for (int k = 0; k < 4; k++)
      if (e[3*k + 2]) g[int'(e[3*k +: 2]) * 4 + k] = 1'b1;
    return g;
  endfunction

  // {expected error, entry}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 12'hFAC},   // full identity matching
    {1'b0, 12'h000},   // empty matching
    {1'b1, 12'h036},   // outputs 0,1 both from input 2
    {1'b0, 12'h016},   // same source, second output idle: legal
    {1'b1, 12'hA05},   // outputs 0,3 both from input 1
    {1'b0, 12'h977}    // reversed full matching
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input int a, input logic [11:0] d, output logic a_ack, output logic a_err);
    we = 1'b1; addr = 10'(a); data = d;
    tick(1);
    a_ack = ack; a_err = err;
    we = 1'b0;
  endtask

  task automatic chk_slot(input string req, input int s, input logic [11:0] e);
    chk({req, " slot"}, 32'(slot), 32'(s));
    chk({req, " map"}, 32'(map), 32'(e));
    chk({req, " grant"}, 32'(grant), 32'(exp_grant(e)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic a, e;
    int acks;
    @(negedge clk);
    tick(2);
    // R1 reset state
    chk("R1 map", 32'(map), 0);
    chk("R1 grant", 32'(grant), 0);
    chk("R1 ack/err/frame", {29'd0, ack, err, fstart}, 0);
    rst_n = 1'b1;
    tick(1);

    // R8 R9 vector walk on one address
    for (int n = 0; n < 6; n++) begin
      wr(FRAME - 1, VEC[n][11:0], a, e);
      chk("R9 err pulse", 32'(e), 32'(VEC[n][12]));
      chk("R8 ack pulse", 32'(a), 32'(!VEC[n][12]));
    end
    tick(1);
    chk("R8 ack single cycle", {30'd0, ack, err}, 0);

    // fill table
    acks = 0;
    for (int i = 0; i < FRAME; i++) begin
      wr(i, pat(i), a, e);
      acks += int'(a);
    end
    chk("R8 load acks", 32'(acks), 32'(FRAME));

    // refused entry must leave pat(1023) in place
    wr(FRAME - 1, 12'h036, a, e);
    chk("R9 refused", {30'd0, a, e}, 32'b01);

    // R6 start at offset 1022
    offset = 10'd1022; run = 1'b1;
    tick(1);
    chk_slot("R6 start", 1022, pat(1022));
    chk("R7 no pulse", 32'(fstart), 0);
    tick(12);
    chk("R4 dwell", 32'(slot), 1022);
    tick(1);
    chk_slot("R4/R9 next slot", 1023, pat(1023));
    tick(13);
    chk_slot("R5 wrap", 0, pat(0));
    chk("R7 frame pulse", 32'(fstart), 1);
    tick(1);
    chk("R7 pulse ends", 32'(fstart), 0);
    tick(11);
    // R8 write while running lands at start of slot 1
    wr(2, 12'h977, a, e);
    chk("R8 blocked", {30'd0, a, e}, 0);
    chk_slot("R3 slot1", 1, pat(1));
    tick(13);
    chk_slot("R8 unchanged", 2, pat(2));

    // R2 halt
    run = 1'b0;
    tick(1);
    chk("R2 map", 32'(map), 0);
    chk("R2 grant", 32'(grant), 0);

    // R6 rotated restart
    offset = 10'd4; run = 1'b1;
    tick(1);
    chk_slot("R6 restart", 4, pat(4));
    chk("R7 no pulse off zero", 32'(fstart), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule